// File: doc/BRIEF.md
# March Algorithm Memory Self-Test Sequencer

This block is a built-in self-test engine for one single-port synchronous RAM whose read data appears one clock after the read is issued. After a start pulse it plays a chosen march algorithm against the whole address space. A march algorithm is an ordered list of elements. Each element is a short list of read-and-expect or write operations. The element applies its entire list to one address before it moves on to the next address, walking the addresses upward or downward. Every written or expected word is the element's 0/1 value copied into every data bit.

Two options extend each algorithm. The first appends a read-back of the freshly written value to the elements that both read and end in a write, so that every cell is seen returning a 0 and a 1 (this exposes cells that cannot be reached at all). The second inserts a programmable idle wait after the all-zero initialisation element and after the element that leaves every cell at 1. These waits let leaky cells lose their contents, and the wait counter is wide enough for waits of hundreds of milliseconds. Each read result is compared one cycle after issue. The first mismatch is recorded with its address, its expected word and the word that came back. A mode input chooses whether the run continues or halts on that mismatch.

Top module: `mbist_march_seq`

## Requirements
- R1: After reset, ram_en, busy, done and fail are 0. A start pulse in the idle or finished state begins a run and drops done. busy is 1 while the run lasts. done rises after the run and stays at 1 until the next accepted start.
- R2: algo_sel, latched at start, picks the algorithm, where U is ascending, D is descending, and an element with no required order runs ascending. 0 gives MATS+: U(w0); U(r0,w1); D(r1,w0). 1 gives March C-: U(w0); U(r0,w1); U(r1,w0); D(r0,w1); D(r1,w0); U(r0). 2 gives March A: U(w0); U(r0,w1,w0,w1); U(r1,w0,w1); D(r1,w0,w1,w0); D(r0,w1,w0). 3 gives March B, which is March A with the second element replaced by U(r0,w1,r1,w0,r0,w1).
- R3: Exactly one operation is issued per cycle that ram_en is 1. An element runs all of its operations on one address before it moves to the next. Ascending order visits 0 to n-1. Descending order visits the exact reverse, n-1 down to 0.
- R4: With the wait option off, no idle cycle falls between operations of one run. The run issues exactly 5n, 10n, 15n or 17n operations for algorithms 0 to 3, with n = 2^AW.
- R5: With sopen_en set at start, every element that contains a read and ends with a write gets one more read, which expects the last value written. No other element changes.
- R6: With hold_en set at start and hold_cycles H nonzero, exactly H cycles with ram_en at 0 separate element 0 from element 1, and element 1 from element 2. With H = 0 no wait is added.
- R7: ram_wdata on a write is the operation's bit copied across all DW bits. ram_we is 1 only on write operations.
- R8: Read data is compared with the replicated expected bit in the cycle after the read is issued. The first mismatch sets fail and captures fail_addr, fail_exp and fail_act. Later mismatches do not change them. The next accepted start clears fail.
- R9: With stop_on_fail set at start, the operation issued in the cycle the mismatching data returns is the last one, and done follows in the next cycle. With it clear, the full sequence runs.
- R10: start pulses and changes to the option inputs while busy do not alter the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (taken only when not busy) |
| algo_sel | input | 2 | Algorithm select (0 MATS+, 1 March C-, 2 March A, 3 March B) |
| sopen_en | input | 1 | Append read-back reads |
| hold_en | input | 1 | Enable retention waits |
| hold_cycles | input | HOLD_W | Length of each retention wait in cycles |
| stop_on_fail | input | 1 | Halt at the first mismatch |
| ram_rdata | input | DW | RAM read data, valid one cycle after a read |
| ram_en | output | 1 | RAM access strobe |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | AW | RAM address |
| ram_wdata | output | DW | RAM write data |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| fail | output | 1 | A mismatch was seen in this run |
| fail_addr | output | AW | Address of the first mismatch |
| fail_exp | output | DW | Expected word at the first mismatch |
| fail_act | output | DW | Returned word at the first mismatch |

## Verification
A wrong element or operation index shows at once as an address, write-enable or write-data value that departs from the expected operation stream in the same cycle it is issued. A wrong wait count shows as a different number of idle cycles between elements. A bad read pipeline or capture shows as fail or the captured fields being wrong two cycles after the faulty read. A stop-mode defect shows as an operation count that differs from the exact expected total.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

  localparam int MAX_OPS   = 7;
  localparam int MAX_ELEMS = 6;
  localparam int OPC_W     = $clog2(MAX_OPS + 1);
  localparam int EL_W      = $clog2(MAX_ELEMS);

  typedef enum logic [1:0] {
    ALG_MATS_PLUS = 2'd0,
    ALG_MARCH_CM  = 2'd1,
    ALG_MARCH_A   = 2'd2,
    ALG_MARCH_B   = 2'd3
  } alg_e;

  typedef struct packed {
    logic is_wr;
    logic val;
  } mop_t;

  typedef struct packed {
    logic                     down;
    logic [OPC_W-1:0]         nops;
    mop_t [MAX_OPS-1:0]       ops;
  } melem_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RUN, ST_HOLD, ST_DRAIN, ST_DONE
  } st_e;

  localparam mop_t OP_R0   = 2'b00;
  localparam mop_t OP_R1   = 2'b01;
  localparam mop_t OP_W0   = 2'b10;
  localparam mop_t OP_W1   = 2'b11;
  localparam mop_t OP_NONE = 2'b00;

  function automatic melem_t mk_elem(input logic dn, input logic [OPC_W-1:0] n,
                                     input mop_t o0, input mop_t o1, input mop_t o2,
                                     input mop_t o3, input mop_t o4, input mop_t o5);
    melem_t e;
    e        = '0;
    e.down   = dn;
    e.nops   = n;
    e.ops[0] = o0;
    e.ops[1] = o1;
    e.ops[2] = o2;
    e.ops[3] = o3;
    e.ops[4] = o4;
    e.ops[5] = o5;
    return e;
  endfunction

endpackage

// File: rtl/mbist_prog.sv
module mbist_prog
  import mbist_pkg::*;
(
  input  logic [1:0]      alg,
  input  logic            sopen,
  input  logic [EL_W-1:0] elem_idx,
  output melem_t          elem,
  output logic            last_elem
);

  melem_t          base;
  logic [EL_W-1:0] n_el;
  logic            has_rd;

  // Base element table per algorithm (R2)
  always_comb begin
    base = '0;
    n_el = EL_W'(3);
    case (alg)
      ALG_MATS_PLUS: begin
        n_el = EL_W'(3);
        case (elem_idx)
          0: base = mk_elem(1'b0, 1, OP_W0, OP_NONE, OP_NONE, OP_NONE, OP_NONE, OP_NONE);
          1: base = mk_elem(1'b0, 2, OP_R0, OP_W1, OP_NONE, OP_NONE, OP_NONE, OP_NONE);
          2: base = mk_elem(1'b1, 2, OP_R1, OP_W0, OP_NONE, OP_NONE, OP_NONE, OP_NONE);
          default: base = '0;
        endcase
      end
      ALG_MARCH_CM: begin
        n_el = EL_W'(6);
        case (elem_idx)
          0: base = mk_elem(1'b0, 1, OP_W0, OP_NONE, OP_NONE, OP_NONE, OP_NONE, OP_NONE);
          1: base = mk_elem(1'b0, 2, OP_R0, OP_W1, OP_NONE, OP_NONE, OP_NONE, OP_NONE);
          2: base = mk_elem(1'b0, 2, OP_R1, OP_W0, OP_NONE, OP_NONE, OP_NONE, OP_NONE);
          3: base = mk_elem(1'b1, 2, OP_R0, OP_W1, OP_NONE, OP_NONE, OP_NONE, OP_NONE);
          4: base = mk_elem(1'b1, 2, OP_R1, OP_W0, OP_NONE, OP_NONE, OP_NONE, OP_NONE);
          5: base = mk_elem(1'b0, 1, OP_R0, OP_NONE, OP_NONE, OP_NONE, OP_NONE, OP_NONE);
          default: base = '0;
        endcase
      end
      default: begin
        n_el = EL_W'(5);
        case (elem_idx)
          0: base = mk_elem(1'b0, 1, OP_W0, OP_NONE, OP_NONE, OP_NONE, OP_NONE, OP_NONE);
          1: begin
            if (alg == ALG_MARCH_B)
              base = mk_elem(1'b0, 6, OP_R0, OP_W1, OP_R1, OP_W0, OP_R0, OP_W1);
            else
              base = mk_elem(1'b0, 4, OP_R0, OP_W1, OP_W0, OP_W1, OP_NONE, OP_NONE);
          end
          2: base = mk_elem(1'b0, 3, OP_R1, OP_W0, OP_W1, OP_NONE, OP_NONE, OP_NONE);
          3: base = mk_elem(1'b1, 4, OP_R1, OP_W0, OP_W1, OP_W0, OP_NONE, OP_NONE);
          4: base = mk_elem(1'b1, 3, OP_R0, OP_W1, OP_W0, OP_NONE, OP_NONE, OP_NONE);
          default: base = '0;
        endcase
      end
    endcase
  end

  // Read-back insertion (R5)
  always_comb begin
    elem   = base;
    has_rd = 1'b0;
    for (int k = 0; k < MAX_OPS; k++) begin
      if (k < int'(base.nops) && !base.ops[k].is_wr) has_rd = 1'b1;
    end
    if (sopen && has_rd && base.nops != '0 && base.ops[base.nops - 1'b1].is_wr) begin
      elem.ops[base.nops] = {1'b0, base.ops[base.nops - 1'b1].val};
      elem.nops           = base.nops + 1'b1;
    end
  end

  assign last_elem = (elem_idx == n_el - 1'b1);

endmodule

// File: rtl/mbist_addr_gen.sv
module mbist_addr_gen #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic          down,
  output logic [AW-1:0] addr,
  output logic          at_end
);

  logic [AW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (step) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (clr || step) cnt_q <= cnt_d;
  end

  // Descending order is the bitwise mirror of the ascending count (R3)
  assign addr   = down ? ~cnt_q : cnt_q;
  assign at_end = &cnt_q;

  a_r3_count_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && !at_end) |=> (cnt_q == $past(cnt_q) + 1'b1))
    else $error("R3 address counter did not advance by one");

endmodule

// File: rtl/mbist_resp_chk.sv
module mbist_resp_chk #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          rd_issue,
  input  logic [AW-1:0] rd_addr,
  input  logic          rd_val,
  input  logic [DW-1:0] rdata,
  output logic          mis,
  output logic          fail,
  output logic [AW-1:0] fail_addr,
  output logic [DW-1:0] fail_exp,
  output logic [DW-1:0] fail_act
);

  logic          pend_v_q;
  logic [AW-1:0] pend_addr_q;
  logic          pend_val_q;
  logic [DW-1:0] exp_word;
  logic          capture;
  logic          fail_q, fail_d;
  logic [AW-1:0] faddr_q;
  logic [DW-1:0] fexp_q, fact_q;

  assign exp_word = {DW{pend_val_q}};
  assign mis      = pend_v_q && (rdata != exp_word);
  assign capture  = mis && !fail_q && !clear;

  always_comb begin
    fail_d = fail_q;
    if (clear)        fail_d = 1'b0;
    else if (capture) fail_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v_q    <= 1'b0;
      pend_addr_q <= '0;
      pend_val_q  <= 1'b0;
    end else begin
      pend_v_q <= rd_issue;
      if (rd_issue) begin
        pend_addr_q <= rd_addr;
        pend_val_q  <= rd_val;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q  <= 1'b0;
      faddr_q <= '0;
      fexp_q  <= '0;
      fact_q  <= '0;
    end else begin
      fail_q <= fail_d;
      if (capture) begin
        faddr_q <= pend_addr_q;
        fexp_q  <= exp_word;
        fact_q  <= rdata;
      end
    end
  end

  assign fail      = fail_q;
  assign fail_addr = faddr_q;
  assign fail_exp  = fexp_q;
  assign fail_act  = fact_q;

  a_r8_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !clear) |=> fail)
    else $error("R8 fail dropped without a new start");

  a_r8_first_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !clear) |=> ($stable(fail_addr) && $stable(fail_act)))
    else $error("R8 first failure record overwritten");

endmodule

// File: rtl/mbist_march_seq.sv
module mbist_march_seq
  import mbist_pkg::*;
#(
  parameter int AW     = 4,
  parameter int DW     = 8,
  parameter int HOLD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        algo_sel,
  input  logic              sopen_en,
  input  logic              hold_en,
  input  logic [HOLD_W-1:0] hold_cycles,
  input  logic              stop_on_fail,
  input  logic [DW-1:0]     ram_rdata,
  output logic              ram_en,
  output logic              ram_we,
  output logic [AW-1:0]     ram_addr,
  output logic [DW-1:0]     ram_wdata,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [AW-1:0]     fail_addr,
  output logic [DW-1:0]     fail_exp,
  output logic [DW-1:0]     fail_act
);

  localparam int WAIT_ELEMS = 2;

  st_e               st_q, st_d;
  logic [EL_W-1:0]   el_q, el_d;
  logic [OPC_W-1:0]  op_q, op_d;
  logic [HOLD_W-1:0] hc_q, hc_d;

  logic [1:0]        alg_q;
  logic              so_q, hen_q, stop_q;
  logic [HOLD_W-1:0] hcyc_q;

  melem_t            elem;
  logic              last_elem;
  mop_t              cur_op;
  logic              last_op;
  logic              at_end;
  logic              accept;
  logic              mis;
  logic              step;

  assign accept = start && (st_q == ST_IDLE || st_q == ST_DONE);

  // Configuration captured once per run (R10)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alg_q  <= '0;
      so_q   <= 1'b0;
      hen_q  <= 1'b0;
      stop_q <= 1'b0;
      hcyc_q <= '0;
    end else if (accept) begin
      alg_q  <= algo_sel;
      so_q   <= sopen_en;
      hen_q  <= hold_en;
      stop_q <= stop_on_fail;
      hcyc_q <= hold_cycles;
    end
  end

  mbist_prog u_prog (
    .alg       (alg_q),
    .sopen     (so_q),
    .elem_idx  (el_q),
    .elem      (elem),
    .last_elem (last_elem)
  );

  assign cur_op  = elem.ops[op_q];
  assign last_op = (op_q == elem.nops - 1'b1);
  assign step    = ram_en && last_op;

  mbist_addr_gen #(.AW(AW)) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (accept),
    .step   (step),
    .down   (elem.down),
    .addr   (ram_addr),
    .at_end (at_end)
  );

  assign ram_en    = (st_q == ST_RUN);
  assign ram_we    = ram_en && cur_op.is_wr;
  assign ram_wdata = {DW{cur_op.val}};
  assign busy      = (st_q == ST_RUN) || (st_q == ST_HOLD) || (st_q == ST_DRAIN);
  assign done      = (st_q == ST_DONE);

  mbist_resp_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (accept),
    .rd_issue  (ram_en && !cur_op.is_wr),
    .rd_addr   (ram_addr),
    .rd_val    (cur_op.val),
    .rdata     (ram_rdata),
    .mis       (mis),
    .fail      (fail),
    .fail_addr (fail_addr),
    .fail_exp  (fail_exp),
    .fail_act  (fail_act)
  );

  always_comb begin
    st_d = st_q;
    el_d = el_q;
    op_d = op_q;
    hc_d = hc_q;
    case (st_q)
      ST_IDLE, ST_DONE: begin
        if (accept) begin
          st_d = ST_RUN;
          el_d = '0;
          op_d = '0;
        end
      end
      ST_RUN: begin
        if (stop_q && mis) begin
          st_d = ST_DONE;
        end else if (last_op) begin
          op_d = '0;
          if (at_end) begin
            if (last_elem) begin
              st_d = ST_DRAIN;
            end else begin
              el_d = el_q + 1'b1;
              if (hen_q && (int'(el_q) < WAIT_ELEMS) && (hcyc_q != '0)) begin
                st_d = ST_HOLD;
                hc_d = hcyc_q;
              end
            end
          end
        end else begin
          op_d = op_q + 1'b1;
        end
      end
      ST_HOLD: begin
        if (stop_q && mis)        st_d = ST_DONE;
        else if (hc_q <= 1)       st_d = ST_RUN;
        else                      hc_d = hc_q - 1'b1;
      end
      ST_DRAIN: st_d = ST_DONE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      el_q <= '0;
      op_q <= '0;
      hc_q <= '0;
    end else begin
      st_q <= st_d;
      el_q <= el_d;
      op_q <= op_d;
      hc_q <= hc_d;
    end
  end

  a_r3_same_cell: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && !last_op) |=> (st_q != ST_RUN || $stable(ram_addr)))
    else $error("R3 address moved inside an element");

  a_r1_done_held: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done)
    else $error("R1 done dropped without start");

  a_r9_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && mis && st_q == ST_RUN) |=> (done && !ram_en))
    else $error("R9 run continued after mismatch in stop mode");

endmodule

// File: tb/tb_mbist_march_seq.sv
module tb_mbist_march_seq;

  localparam int AW         = 4;
  localparam int DW         = 8;
  localparam int HOLD_W     = 32;
  localparam int N          = 1 << AW;
  localparam int CLK_PERIOD = 10;

  logic              clk, rst_n, start, sopen_en, hold_en, stop_on_fail;
  logic [1:0]        algo_sel;
  logic [HOLD_W-1:0] hold_cycles;
  logic [DW-1:0]     ram_rdata;
  logic              ram_en, ram_we, busy, done, fail;
  logic [AW-1:0]     ram_addr, fail_addr;
  logic [DW-1:0]     ram_wdata, fail_exp, fail_act;

  mbist_march_seq #(.AW(AW), .DW(DW), .HOLD_W(HOLD_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .algo_sel(algo_sel),
    .sopen_en(sopen_en), .hold_en(hold_en), .hold_cycles(hold_cycles),
    .stop_on_fail(stop_on_fail), .ram_rdata(ram_rdata),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr),
    .fail_exp(fail_exp), .fail_act(fail_act)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // RAM model with injectable stuck-at-1 on bit 0
  logic [DW-1:0] mem [N];
  logic [N-1:0]  stuck;
  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) mem[ram_addr] <= stuck[ram_addr] ? (ram_wdata | DW'(1)) : ram_wdata;
      else        ram_rdata     <= mem[ram_addr];
    end
  end

  typedef struct {
    int            addr;
    bit            we;
    logic [DW-1:0] data;
    int            gap;
  } exp_t;

  exp_t expq[$];
  int   n_cmp = 0, n_bad = 0;
  bit   mon_en = 0, sb_on = 0;
  int   op_seen = 0, idle_run = 0, n_exp = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int n_elems(input int alg);
    case (alg)
      0: return 3;
      1: return 6;
      default: return 5;
    endcase
  endfunction

  // Element lists straight from R2: U/D then op pairs
  function automatic string spec(input int alg, input int e);
    case (alg*8 + e)
      0: return "Uw0";   1: return "Ur0w1";   2: return "Dr1w0";
      8: return "Uw0";   9: return "Ur0w1";  10: return "Ur1w0";
      11: return "Dr0w1"; 12: return "Dr1w0"; 13: return "Ur0";
      16: return "Uw0";  17: return "Ur0w1w0w1"; 18: return "Ur1w0w1";
      19: return "Dr1w0w1w0"; 20: return "Dr0w1w0";
      24: return "Uw0";  25: return "Ur0w1r1w0r0w1"; 26: return "Ur1w0w1";
      27: return "Dr1w0w1w0"; 28: return "Dr0w1w0";
      default: return "";
    endcase
  endfunction

  task automatic push_algo(input int alg, input bit so, input int hold);
    for (int e = 0; e < n_elems(alg); e++) begin
      string s;
      bit    dn, has_rd;
      bit    isw [8];
      bit    v   [8];
      int    nop;
      s = spec(alg, e);
      dn = (s[0] == "D");
      nop = 0;
      has_rd = 0;
      for (int k = 1; k + 1 < s.len() + 1; k += 2) begin
        isw[nop] = (s[k] == "w");
        v[nop]   = (s[k+1] == "1");
        if (!isw[nop]) has_rd = 1;
        nop++;
      end
      if (so && has_rd && isw[nop-1]) begin   // R5 read-back
        isw[nop] = 0;
        v[nop]   = v[nop-1];
        nop++;
      end
      for (int i = 0; i < N; i++) begin
        for (int j = 0; j < nop; j++) begin
          exp_t it;
          it.addr = dn ? (N - 1 - i) : i;
          it.we   = isw[j];
          it.data = {DW{v[j]}};
          if (e == 0 && i == 0 && j == 0) it.gap = -1;
          else if (i == 0 && j == 0 && (e == 1 || e == 2)) it.gap = hold;
          else it.gap = 0;
          expq.push_back(it);
        end
      end
    end
    n_exp = expq.size();
  endtask

  // Monitor: pops one expected operation per issued access
  always @(negedge clk) begin
    if (mon_en) begin
      if (ram_en) begin
        op_seen++;
        if (sb_on) begin
          if (expq.size() == 0) begin
            chk(0, "R4", "extra operation", op_seen, n_exp);
          end else begin
            exp_t it;
            bit ok;
            it = expq.pop_front();
            ok = (int'(ram_addr) == it.addr) && (ram_we == it.we) &&
                 (!it.we || ram_wdata == it.data) && (it.gap < 0 || idle_run == it.gap);
            n_cmp++;
            if (!ok) begin
              n_bad++;
              if (int'(ram_addr) != it.addr)
                $display("FAIL R3 addr: got %0h expected %0h", ram_addr, it.addr);
              else if (ram_we != it.we)
                $display("FAIL R2 we: got %0h expected %0h", ram_we, it.we);
              else if (it.we && ram_wdata != it.data)
                $display("FAIL R7 wdata: got %0h expected %0h", ram_wdata, it.data);
              else if (it.gap > 0)
                $display("FAIL R6 idle gap: got %0d expected %0d", idle_run, it.gap);
              else
                $display("FAIL R4 idle gap: got %0d expected %0d", idle_run, it.gap);
            end
          end
        end
        idle_run = 0;
      end else begin
        idle_run++;
      end
    end
  end

  task automatic run(input int alg, input bit so, input int hold, input bit stop,
                     input int poke, input bit cmp);
    expq.delete();
    if (cmp) push_algo(alg, so, hold);
    op_seen = 0;
    idle_run = 0;
    sb_on = cmp;
    mon_en = 1;
    @(posedge clk); #1;
    algo_sel = 2'(alg); sopen_en = so; hold_en = (hold > 0);
    hold_cycles = HOLD_W'(hold); stop_on_fail = stop; start = 1;
    @(posedge clk); #1;
    start = 0;
    if (poke > 0) begin   // R10: start and options disturbed mid-run
      repeat (poke) @(posedge clk);
      #1;
      start = 1; algo_sel = 2'(alg ^ 1); sopen_en = !so; stop_on_fail = !stop;
      @(posedge clk); #1;
      start = 0;
    end
    for (int c = 0; c < 5000; c++) begin
      @(negedge clk);
      if (done) break;
    end
    mon_en = 0;
    chk(done === 1'b1, "R1", "done after run", done, 1);
    chk(busy === 1'b0, "R1", "busy after run", busy, 0);
    if (cmp) chk(op_seen == n_exp && expq.size() == 0, "R4", "operation count", op_seen, n_exp);
  endtask

  initial begin
    for (int i = 0; i < N; i++) mem[i] = '0;
    rst_n = 0; start = 0; algo_sel = 0; sopen_en = 0; hold_en = 0;
    hold_cycles = '0; stop_on_fail = 0; stuck = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(ram_en == 0, "R1", "reset ram_en", ram_en, 0);
    chk(busy == 0,   "R1", "reset busy", busy, 0);
    chk(done == 0,   "R1", "reset done", done, 0);
    chk(fail == 0,   "R1", "reset fail", fail, 0);

    run(0, 0, 0, 0, 0, 1);                       // R2 MATS+
    chk(fail == 0, "R8", "clean MATS+ fail", fail, 0);
    run(1, 0, 3, 0, 0, 1);                       // R6 March C- with waits
    chk(fail == 0, "R8", "clean March C- fail", fail, 0);
    run(2, 1, 0, 0, 0, 1);                       // R5 March A with read-back
    run(3, 1, 2, 0, 40, 1);                      // R10 March B, poke while busy
    chk(fail == 0, "R10", "clean March B fail", fail, 0);
    run(0, 1, 0, 0, 0, 1);                       // R5 MATS+ read-back
    run(2, 0, 0, 0, 0, 1);                       // R4 March A length

    stuck = '0; stuck[5] = 1; stuck[9] = 1;      // R8 two faulty cells
    run(0, 0, 0, 0, 0, 1);
    chk(fail == 1, "R8", "fail set", fail, 1);
    chk(fail_addr == 5, "R8", "first fail_addr kept", fail_addr, 5);
    chk(fail_exp == 8'h00, "R8", "fail_exp", fail_exp, 0);
    chk(fail_act == 8'h01, "R8", "fail_act", fail_act, 1);

    stuck = '0; stuck[9] = 1;                    // R9 stop on first mismatch
    run(1, 0, 0, 1, 0, 0);
    chk(op_seen == 36, "R9", "ops before stop", op_seen, 36);
    chk(fail_addr == 9, "R9", "stop fail_addr", fail_addr, 9);

    stuck = '0;                                  // R8 clear on next start
    run(0, 0, 0, 0, 0, 1);
    chk(fail == 0, "R8", "fail cleared by start", fail, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule